// File: doc/BRIEF.md
# Windowed Clock/Data Pulse Separator

This block takes the raw pulse stream from a disc read channel, where each pulse marks one flux transition, and splits it into two serial bit streams. A free-running cell phase counter, driven by a fast sample clock, divides time into bit cells. The first half of each cell is the clock window and the second half is the data window. A pulse is sorted by the window it lands in. At the end of every cell the block emits one clock bit and one data bit together with a one-cycle strobe. This is the FM recording format, where every cell carries a clock pulse and an optional data pulse.

Only clock-window pulses steer the phase counter, and each one moves it by one sample toward the centre of the clock window, so cell timing stays locked to the recorded clock bits. The block also grades every accepted pulse by its distance to the nearest window edge. A pulse close to an edge still decodes normally, but it sets a sticky margin warning. Firmware reads that warning after a read and clears it explicitly. A read that decoded correctly can still be reported as marginal when the request was a verify.

Top module: `flux_window_sorter`

## Requirements
- R1: While `rd_en` is high, a bit cell lasts CELL_LEN (32) sample cycles, and the cell phase starts at 0 on the first enabled cycle. Phases 0..15 form the clock window and phases 16..31 form the data window.
- R2: In the cycle after the cell phase reaches 31, `bit_stb` is high for exactly one cycle. `clk_bit` and `dat_bit` carry that cell's result in the same cycle. Both bits are 0 whenever `bit_stb` is low.
- R3: A pulse is a rising edge of `pulse_in`, meaning a low sample followed by a high sample. A window with at least one pulse yields 1, and a window with none yields 0.
- R4: A pulse in the clock window at offset 0..6 advances the phase by 2 in place of 1, which shortens the cell by one cycle. A clock-window pulse at offset 9..15 holds the phase for one cycle, which lengthens the cell by one. Offsets 7 and 8, and all data-window pulses, leave the count unchanged.
- R5: A pulse at window offset 0..2 or 13..15, in either window, sets `margin_flag` from the next cycle. The pulse is still classified normally.
- R6: `margin_flag` stays set until `margin_clr` is sampled high. If a new marginal pulse arrives in the same cycle as the clear, the flag stays set.
- R7: While `rd_en` is low, the phase is held at 0, no strobe is produced, pulses do not set the margin flag, and any partially collected cell is discarded.
- R8: During reset, `bit_stb`, `clk_bit`, `dat_bit` and `margin_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, CELL_LEN cycles per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read enable; low holds the separator idle |
| pulse_in | input | 1 | Raw read pulse stream, one rising edge per flux transition |
| margin_clr | input | 1 | Clears the sticky margin warning |
| clk_bit | output | 1 | Separated clock bit, valid with `bit_stb` |
| dat_bit | output | 1 | Separated data bit, valid with `bit_stb` |
| bit_stb | output | 1 | One-cycle strobe at the end of each bit cell |
| margin_flag | output | 1 | Sticky warning that a pulse fell near a window edge |

## Verification
The hardest situations to reach are cells whose length has been changed by the phase nudge, and a clear that coincides with a new marginal pulse. Both depend on the phase at which a pulse lands, and that phase is itself shifted by earlier pulses. The driver therefore keeps its own running model of the cell phase. It fires each pulse when the model reaches a chosen offset, so early, late, edge-hugging and same-cycle clear cases can be placed exactly. Strobe timing is then checked against the model in every cycle, so a cell that is one sample too long or too short is reported at once.

// File: rtl/fws_pkg.sv
package fws_pkg;

  // Phase correction requested by the window grader
  typedef enum logic [1:0] {
    NUDGE_NONE    = 2'd0,
    NUDGE_ADVANCE = 2'd1,
    NUDGE_RETARD  = 2'd2
  } nudge_e;

  // Grading of the sample in the current cycle
  typedef struct packed {
    logic hit;       // accepted pulse edge this cycle
    logic in_data;   // pulse lies in the data window
    logic marginal;  // pulse lies near a window edge
  } pulse_info_t;

endpackage

// File: rtl/fws_edge_det.sv
module fws_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic edge_o
);

  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = pulse_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign edge_o = pulse_in & ~pulse_q;

endmodule

// File: rtl/fws_phase_tracker.sv
module fws_phase_tracker
  import fws_pkg::*;
#(
  parameter int CELL_LEN = 32,
  localparam int PW = $clog2(CELL_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  nudge_e        nudge,
  output logic [PW-1:0] phase_o,
  output logic          cell_end_o
);

  localparam logic [PW-1:0] LAST_PHASE = PW'(CELL_LEN - 1);
  localparam logic [PW-1:0] STEP_ONE   = PW'(1);
  localparam logic [PW-1:0] STEP_TWO   = PW'(2);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  // Next-state: wrap is implicit because CELL_LEN is a power of two
  always_comb begin
    phase_d = phase_q;
    if (!en) begin
      phase_d = '0;
    end else begin
      unique case (nudge)
        NUDGE_ADVANCE: phase_d = phase_q + STEP_TWO;
        NUDGE_RETARD:  phase_d = phase_q;
        default:       phase_d = phase_q + STEP_ONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_o    = phase_q;
  assign cell_end_o = en && (phase_q == LAST_PHASE);

endmodule

// File: rtl/fws_window_grader.sv
module fws_window_grader
  import fws_pkg::*;
#(
  parameter int CELL_LEN = 32,
  parameter int MARGIN   = 3,
  localparam int PW = $clog2(CELL_LEN)
) (
  input  logic [PW-1:0] phase,
  input  logic          edge_i,
  input  logic          en,
  output pulse_info_t   info_o,
  output nudge_e        nudge_o
);

  localparam int HALF   = CELL_LEN / 2;
  localparam int OW     = PW - 1;
  localparam int CEN_LO = HALF / 2 - 1;
  localparam int CEN_HI = HALF / 2;

  logic [OW-1:0] offset;
  logic          in_data;
  logic          hit;
  logic          near_edge;

  assign offset  = phase[OW-1:0];
  assign in_data = phase[PW-1];
  assign hit     = edge_i && en;

  // Variant chosen by parameter: margin grading can be compiled out
  generate
    if (MARGIN > 0) begin : g_margin
      always_comb begin
        near_edge = (offset < OW'(MARGIN)) ||
                    (offset > OW'(HALF - 1 - MARGIN));
      end
    end else begin : g_no_margin
      always_comb begin
        near_edge = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    info_o.hit      = hit;
    info_o.in_data  = in_data;
    info_o.marginal = hit && near_edge;
  end

  // Clock pulses pull the cell toward the clock-window centre
  always_comb begin
    nudge_o = NUDGE_NONE;
    if (hit && !in_data) begin
      if (offset < OW'(CEN_LO)) begin
        nudge_o = NUDGE_ADVANCE;
      end else if (offset > OW'(CEN_HI)) begin
        nudge_o = NUDGE_RETARD;
      end
    end
  end

endmodule

// File: rtl/fws_bit_collector.sv
module fws_bit_collector
  import fws_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  pulse_info_t info,
  input  logic        cell_end,
  output logic        clk_bit_o,
  output logic        dat_bit_o,
  output logic        stb_o
);

  logic acc_clk_q, acc_clk_d;
  logic acc_dat_q, acc_dat_d;
  logic out_clk_q, out_clk_d;
  logic out_dat_q, out_dat_d;
  logic stb_q, stb_d;
  logic clk_seen, dat_seen;

  always_comb begin
    clk_seen  = acc_clk_q | (info.hit & ~info.in_data);
    dat_seen  = acc_dat_q | (info.hit &  info.in_data);
    acc_clk_d = clk_seen;
    acc_dat_d = dat_seen;
    out_clk_d = 1'b0;
    out_dat_d = 1'b0;
    stb_d     = 1'b0;
    if (!en) begin
      acc_clk_d = 1'b0;
      acc_dat_d = 1'b0;
    end else if (cell_end) begin
      out_clk_d = clk_seen;
      out_dat_d = dat_seen;
      stb_d     = 1'b1;
      acc_clk_d = 1'b0;
      acc_dat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_clk_q <= 1'b0;
      acc_dat_q <= 1'b0;
      out_clk_q <= 1'b0;
      out_dat_q <= 1'b0;
      stb_q     <= 1'b0;
    end else begin
      acc_clk_q <= acc_clk_d;
      acc_dat_q <= acc_dat_d;
      out_clk_q <= out_clk_d;
      out_dat_q <= out_dat_d;
      stb_q     <= stb_d;
    end
  end

  assign clk_bit_o = out_clk_q;
  assign dat_bit_o = out_dat_q;
  assign stb_o     = stb_q;

endmodule

// File: rtl/fws_margin_flag.sv
module fws_margin_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  // A fresh event outranks a clear in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/flux_window_sorter.sv
module flux_window_sorter
  import fws_pkg::*;
#(
  parameter int CELL_LEN = 32,
  parameter int MARGIN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic pulse_in,
  input  logic margin_clr,
  output logic clk_bit,
  output logic dat_bit,
  output logic bit_stb,
  output logic margin_flag
);

  localparam int PW = $clog2(CELL_LEN);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic          pulse_edge;
  logic [PW-1:0] phase;
  logic          cell_end;
  nudge_e        nudge;
  pulse_info_t   info;

  fws_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .pulse_in (pulse_in),
    .edge_o   (pulse_edge)
  );

  fws_phase_tracker #(.CELL_LEN(CELL_LEN)) u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .en         (rd_en),
    .nudge      (nudge),
    .phase_o    (phase),
    .cell_end_o (cell_end)
  );

  fws_window_grader #(.CELL_LEN(CELL_LEN), .MARGIN(MARGIN)) u_grade (
    .phase   (phase),
    .edge_i  (pulse_edge),
    .en      (rd_en),
    .info_o  (info),
    .nudge_o (nudge)
  );

  fws_bit_collector u_collect (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .en        (rd_en),
    .info      (info),
    .cell_end  (cell_end),
    .clk_bit_o (clk_bit),
    .dat_bit_o (dat_bit),
    .stb_o     (bit_stb)
  );

  fws_margin_flag u_margin (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .set_i  (info.marginal),
    .clr_i  (margin_clr),
    .flag_o (margin_flag)
  );

endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int CELL_LEN = 32,
  localparam int PW = $clog2(CELL_LEN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          margin_clr,
  input logic          bit_stb,
  input logic          clk_bit,
  input logic          dat_bit,
  input logic          margin_flag,
  input logic [PW-1:0] phase
);

  // R2: strobe lasts one cycle
  a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  // R2: bits are quiet outside the strobe
  a_r2_bits_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |-> (!clk_bit && !dat_bit));

  // R1: a strobe coincides with the start of the next cell
  a_r1_stb_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (phase == '0));

  // R7: no strobe follows a disabled cycle
  a_r7_no_stb_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !bit_stb);

  // R7: the flag cannot rise out of a disabled cycle
  a_r7_no_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !margin_flag) |=> !margin_flag);

  // R6: the flag is held until cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (margin_flag && !margin_clr) |=> margin_flag);

  // R7: phase sits at zero after a disabled cycle
  a_r7_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (phase == '0));

endmodule

bind flux_window_sorter fws_checker #(.CELL_LEN(CELL_LEN)) u_fws_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en       (rd_en),
  .margin_clr  (margin_clr),
  .bit_stb     (bit_stb),
  .clk_bit     (clk_bit),
  .dat_bit     (dat_bit),
  .margin_flag (margin_flag),
  .phase       (phase)
);

// File: tb/tb_flux_window_sorter.sv
`timescale 1ns/1ps
module tb_flux_window_sorter;

  logic clk;
  logic rst_n;
  logic rd_en;
  logic pulse_in;
  logic margin_clr;
  logic clk_bit;
  logic dat_bit;
  logic bit_stb;
  logic margin_flag;

  flux_window_sorter dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .pulse_in    (pulse_in),
    .margin_clr  (margin_clr),
    .clk_bit     (clk_bit),
    .dat_bit     (dat_bit),
    .bit_stb     (bit_stb),
    .margin_flag (margin_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit c;
    bit d;
  } cell_t;

  cell_t exp_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    mph   = 0;    // model cell phase
  bit    acc_c = 0;
  bit    acc_d = 0;
  bit    prev  = 0;
  bit    exp_m = 0;
  bit    finished = 0;

  task automatic chk(input string tag, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: every strobe must match the head of the scoreboard, in the right cycle
  always @(negedge clk) begin
    cell_t e;
    if (rst_n && !finished) begin
      if (bit_stb || exp_q.size() > 0) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected strobe", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk("R2 strobe timing", int'(bit_stb), 1);
          chk("R3 clock bit", int'(clk_bit), int'(e.c));
          chk("R3 data bit", int'(dat_bit), int'(e.d));
        end
      end
    end
  end

  // Model of one enabled cycle, taken from R1..R6
  task automatic model_step(input bit fire, input bit cl, output bit done);
    bit e;
    bit marg;
    int p;
    p = mph;
    e = fire && !prev;
    prev = fire;
    if (e) begin
      if (p < 16) acc_c = 1; else acc_d = 1;
    end
    marg = e && (((p % 16) < 3) || ((p % 16) > 12));
    if (marg) exp_m = 1;
    else if (cl) exp_m = 0;
    if (e && p < 16 && p <= 6) mph = p + 2;
    else if (e && p < 16 && p >= 9) mph = p;
    else mph = (p == 31) ? 0 : p + 1;
    done = (p == 31);
    if (done) begin
      cell_t it;
      it.c = acc_c;
      it.d = acc_d;
      exp_q.push_back(it);
      acc_c = 0;
      acc_d = 0;
    end
  endtask

  // Driver: one cell, pulses at model offsets, optional clear, optional early stop
  task automatic run_cell(input int coff, input int doff, input int clr_at, input int stop_after);
    bit sc;
    bit sd;
    bit fire;
    bit cl;
    bit done;
    int n;
    sc = 0; sd = 0; done = 0; n = 0;
    while (!done && (stop_after < 0 || n < stop_after)) begin
      @(negedge clk);
      fire = 0;
      if (coff >= 0 && !sc && mph == coff) begin fire = 1; sc = 1; end
      if (doff >= 0 && !sd && mph == doff) begin fire = 1; sd = 1; end
      cl = (clr_at == mph);
      rd_en      = 1'b1;
      pulse_in   = fire;
      margin_clr = cl;
      @(posedge clk);
      model_step(fire, cl, done);
      n++;
    end
  endtask

  task automatic run_idle(input int cycles, input bit toggle);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rd_en      = 1'b0;
      pulse_in   = toggle && (i % 2 == 0);
      margin_clr = 1'b0;
      @(posedge clk);
      prev  = pulse_in;
      mph   = 0;
      acc_c = 0;
      acc_d = 0;
    end
  endtask

  task automatic chk_margin(input string tag);
    #1;
    chk(tag, int'(margin_flag), int'(exp_m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; pulse_in = 1'b0; margin_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset strobe", int'(bit_stb), 0);
    chk("R8 reset clock bit", int'(clk_bit), 0);
    chk("R8 reset data bit", int'(dat_bit), 0);
    chk("R8 reset margin", int'(margin_flag), 0);
    rst_n = 1'b1;
    run_idle(4, 1'b0);

    // R1 R3: all four bit combinations, centred pulses
    run_cell(7, 23, -1, -1);
    run_cell(7, -1, -1, -1);
    run_cell(-1, 23, -1, -1);
    run_cell(-1, -1, -1, -1);
    run_cell(8, 24, -1, -1);
    chk_margin("R5 centred pulses leave flag clear");

    // R4: early clock pulses shorten cells, late ones lengthen them
    run_cell(4, 23, -1, -1);
    run_cell(11, 20, -1, -1);
    for (int k = 0; k < 4; k++) run_cell(5, 22, -1, -1);
    for (int k = 0; k < 4; k++) run_cell(10, -1, -1, -1);
    chk_margin("R4 nudged cells leave flag clear");

    // R5: clock pulse near the window start
    run_cell(1, -1, -1, -1);
    chk_margin("R5 early clock pulse sets flag");
    run_cell(7, 23, 10, -1);
    chk_margin("R6 clear drops flag");
    run_cell(-1, 30, -1, -1);
    chk_margin("R5 late data pulse sets flag");
    run_cell(7, 23, -1, -1);
    chk_margin("R6 flag is sticky");
    run_cell(2, 23, 2, -1);
    chk_margin("R6 set wins over same-cycle clear");
    run_cell(7, 23, 5, -1);
    chk_margin("R6 clear after collision");
    run_cell(14, 17, -1, -1);
    chk_margin("R5 pulses at window boundary");
    run_cell(-1, -1, 0, -1);
    chk_margin("R6 clear with empty cell");

    // R7: abandon a cell mid-way, pulse while idle, then restart
    run_cell(7, -1, -1, 12);
    run_idle(9, 1'b1);
    chk_margin("R7 idle pulses do not set flag");
    run_cell(-1, -1, -1, -1);
    run_cell(-1, 16, -1, -1);
    run_cell(7, 23, -1, -1);

    run_idle(4, 1'b0);
    chk("R2 all expected strobes seen", exp_q.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule